// File: doc/BRIEF.md
# Two-Frame Serial Register Slave

This block is the serial front end of a register file. An external host drives a four-wire serial bus in mode 3: the clock idles high, data changes on falling edges and is sampled on rising edges. Each transaction while chip select is low is one 16-clock frame. A write frame carries a single data byte for one of 64 byte addresses. A read frame names a byte address. The full 16-bit word holding that byte is then shifted back, most significant bit first, during the frame that follows. A host that polls continuously therefore pays only one extra frame, because every read command also collects the result of the command before it.

The serial lines are sampled by the block's own clock through two-stage synchronizers. The serial clock must be several times slower than the system clock. Writes leave the block as a one-cycle strobe with a byte address and a data byte. Reads present a 5-bit word index on `rd_addr` and take the word from `rd_data`, except for one built-in sample word. That word holds a new-data flag, an alarm flag and a 14-bit sample, and its flag clears itself once the word is read. A frame that does not end after exactly 16 clocks is dropped and raises a sticky failure flag.

Top module: `spi_word_slave`

## Requirements
- R1: A frame is the span with `spi_csn` low. It is accepted only if it contains exactly 16 rising edges of `spi_sclk`, and `spi_mosi` is captured MSB first on those edges.
- R2: An accepted frame whose first two bits are 1 then 0 produces exactly one single-cycle `wr_stb` after chip select rises. `wr_addr` carries bits 13:8 and `wr_byte` carries bits 7:0. First bits 1,1 or 0,1 produce no strobe.
- R3: An accepted frame whose first two bits are 0,0 is a read of byte address bits 13:8. The next frame returns the 16-bit word at word index address[5:1], upper byte first, and both byte addresses of a word return the same word.
- R4: The first return bit is valid shortly after chip select falls. Each later bit changes only after a falling edge of `spi_sclk` that follows a rising edge, so a bit is stable at each rising edge.
- R5: While chip select is high, `spi_miso_oe` is 0 and `spi_miso` is 0, and activity on `spi_sclk` or `spi_mosi` causes no write and changes no returned data.
- R6: The sample word sits at word index 2 (byte addresses 0x04 and 0x05). Bit 15 is the new-data flag, bit 14 the alarm and bits 13:0 the sample. A `smp_valid` pulse loads the word and sets the flag, and an accepted read of the word clears the flag after its value has been captured.
- R7: A frame with fewer or more than 16 rising clock edges writes nothing, latches no read data, leaves the new-data flag alone and sets `spi_fail`, which then stays set until reset.
- R8: Every accepted frame returns the word captured by the most recent accepted read, or zero if no read has been accepted since reset. Frames that are not reads do not change it.
- R9: After reset, `spi_miso_oe`, `spi_miso`, `wr_stb` and `spi_fail` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, 0 when not enabled |
| spi_miso_oe | output | 1 | Output enable for the data pad driver |
| wr_stb | output | 1 | One-cycle byte write strobe |
| wr_addr | output | 6 | Byte address of the write |
| wr_byte | output | 8 | Data byte of the write |
| rd_addr | output | 5 | Word index of the read being decoded |
| rd_data | input | 16 | Word returned by the register file for `rd_addr` |
| smp_valid | input | 1 | New sample pulse |
| smp_data | input | 14 | Sample value |
| smp_alarm | input | 1 | Alarm flag stored with the sample |
| spi_fail | output | 1 | Sticky flag for a frame of the wrong length |

## Verification
Serial inputs take two synchronizer stages and one edge-detect stage, so every serial event reaches the block's state three to four system clocks after the pin changes. The bench holds each half serial period for eight system clocks, so the return bit has settled well before the rising edge where the monitor samples it. The write strobe appears four clocks after chip select rises. The bench waits twelve clocks between frames and pops the write queue at falling system clock edges. A returned word is due one whole frame after its read command, so the driver queues it when it starts the next accepted frame, and the monitor compares it when that frame closes.

// File: rtl/spi_word_slave.sv
module spi_word_slave #(
  parameter logic [4:0] SAMPLE_WORD = 5'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_csn,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        spi_miso_oe,
  output logic        wr_stb,
  output logic [5:0]  wr_addr,
  output logic [7:0]  wr_byte,
  output logic [4:0]  rd_addr,
  input  logic [15:0] rd_data,
  input  logic        smp_valid,
  input  logic [13:0] smp_data,
  input  logic        smp_alarm,
  output logic        spi_fail
);
  localparam int          WORD_W   = 16;
  localparam int          CNT_W    = $clog2(WORD_W) + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0] sclk_q, csn_q;
  logic [1:0] mosi_q;
  logic       in_frame;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] rx, tx, ret_word;
  logic              smp_nd, smp_alm;
  logic [13:0]       smp_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '1;
      csn_q  <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], spi_sclk};
      csn_q  <= {csn_q[1:0], spi_csn};
      mosi_q <= {mosi_q[0], spi_mosi};
    end

  wire sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire sclk_fall = ~sclk_q[1] & sclk_q[2];
  wire cs_fall   = ~csn_q[1] & csn_q[2];
  wire cs_rise   = csn_q[1] & ~csn_q[2];

  wire frame_end = cs_rise & in_frame;
  wire frame_ok  = frame_end & (cnt == FULL);
  wire is_wr     = rx[15:14] == 2'b10;
  wire is_rd     = rx[15:14] == 2'b00;
  wire hit_smp   = rd_addr == SAMPLE_WORD;
  wire [WORD_W-1:0] smp_word = {smp_nd, smp_alm, smp_val};

  assign rd_addr     = rx[13:9];
  assign spi_miso_oe = in_frame;
  assign spi_miso    = in_frame & tx[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_frame <= 1'b0;
      cnt      <= '0;
      rx       <= '0;
      tx       <= '0;
    end else if (cs_fall) begin
      in_frame <= 1'b1;
      cnt      <= '0;
      rx       <= '0;
      tx       <= ret_word;
    end else if (cs_rise) begin
      in_frame <= 1'b0;
    end else if (in_frame) begin
      if (sclk_rise) begin
        rx <= {rx[WORD_W-2:0], mosi_q[1]};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
      if (sclk_fall && cnt != '0) tx <= {tx[WORD_W-2:0], 1'b0};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_byte <= '0;
    end else begin
      wr_stb <= frame_ok & is_wr;
      if (frame_ok && is_wr) begin
        wr_addr <= rx[13:8];
        wr_byte <= rx[7:0];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ret_word <= '0;
    else if (frame_ok && is_rd) ret_word <= hit_smp ? smp_word : rd_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) spi_fail <= 1'b0;
    else if (frame_end && cnt != FULL) spi_fail <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      smp_nd  <= 1'b0;
      smp_alm <= 1'b0;
      smp_val <= '0;
    end else if (smp_valid) begin
      smp_nd  <= 1'b1;
      smp_alm <= smp_alarm;
      smp_val <= smp_data;
    end else if (frame_ok && is_rd && hit_smp) begin
      smp_nd <= 1'b0;
    end

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  assert_strobe_outside_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !spi_miso_oe);
  assert_bit_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_miso_oe && !sclk_fall && !cs_rise) |=> $stable(spi_miso));
  assert_nd_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> smp_nd);
  assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_fail |=> spi_fail);
  assert_fail_at_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_fail) |-> !spi_miso_oe);
endmodule

// File: tb/spi_word_slave_test.sv
module spi_word_slave_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b1, spi_csn = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe, wr_stb, spi_fail;
  logic [5:0] wr_addr;
  logic [7:0] wr_byte;
  logic [4:0] rd_addr;
  logic [15:0] rd_data;
  logic smp_valid = 1'b0, smp_alarm = 1'b0;
  logic [13:0] smp_data = '0;

  int checks = 0, fails = 0;
  localparam int H = 8;

  always #2 clk = ~clk;

  function automatic logic [15:0] reg_val(input logic [4:0] w);
    return {3'b110, w, w[2:0], 5'h0A};
  endfunction
  assign rd_data = reg_val(rd_addr);

  spi_word_slave uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_byte(wr_byte), .rd_addr(rd_addr),
    .rd_data(rd_data), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_alarm(smp_alarm), .spi_fail(spi_fail));

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [13:0] wr_q[$];
  logic [15:0] last_read = '0;
  logic        m_nd = 1'b0, m_alm = 1'b0;
  logic [13:0] m_val = '0;

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] cmd, input int nclk, input string tag);
    if (nclk == 16) begin
      exp_q.push_back(last_read);
      tag_q.push_back(tag);
      if (cmd[15:14] == 2'b10) wr_q.push_back(cmd[13:0]);
    end
    @(negedge clk) spi_csn = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      spi_sclk = 1'b0;
      spi_mosi = (i < 16) ? cmd[15-i] : 1'b0;
      repeat (H) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (H) @(negedge clk);
    end
    spi_csn = 1'b1;
    repeat (12) @(negedge clk);
    check(!spi_miso_oe && !spi_miso, "R5 idle after frame",
          {14'd0, spi_miso_oe, spi_miso}, 16'd0);
    if (nclk == 16 && cmd[15:14] == 2'b00) begin
      if (cmd[13:9] == 5'd2) begin
        last_read = {m_nd, m_alm, m_val};
        m_nd = 1'b0;
      end else last_read = reg_val(cmd[13:9]);
    end
  endtask

  task automatic sample(input logic [13:0] d, input logic a);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = d; smp_alarm = a;
    @(negedge clk) smp_valid = 1'b0;
    m_nd = 1'b1; m_alm = a; m_val = d;
  endtask

  task automatic wiggle();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk) spi_sclk = 1'b0; spi_mosi = i[0];
      repeat (H) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (H) @(negedge clk);
    end
    repeat (12) @(negedge clk);
  endtask

  initial forever begin
    int n;
    logic [15:0] got;
    logic oe_ok;
    @(negedge spi_csn);
    n = 0; got = '0; oe_ok = 1'b1;
    while (spi_csn == 1'b0) begin
      @(posedge spi_sclk or posedge spi_csn);
      if (!spi_csn) begin
        got = {got[14:0], spi_miso};
        oe_ok = oe_ok & spi_miso_oe;
        n++;
      end
    end
    if (n == 16) begin
      logic [15:0] e;
      string t;
      check(oe_ok, "R4 output enabled in frame", {15'd0, oe_ok}, 16'd1);
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected frame", got, 16'hxxxx);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got === e, t, got, e);
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (wr_stb) begin
      if (wr_q.size() == 0) check(1'b0, "R2 unexpected write", {2'b0, wr_addr, wr_byte}, 16'd0);
      else begin
        logic [13:0] w;
        w = wr_q.pop_front();
        check({wr_addr, wr_byte} === w, "R2 write strobe", {2'b0, wr_addr, wr_byte}, {2'b0, w});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!spi_miso_oe && !spi_miso && !wr_stb && !spi_fail, "R9 reset state",
          {12'd0, spi_miso_oe, spi_miso, wr_stb, spi_fail}, 16'd0);

    frame({2'b10, 6'h12, 8'hA5}, 16, "R8 zero before any read");
    sample(14'h2345, 1'b1);
    frame({2'b00, 6'h04, 8'hFF}, 16, "R8 still zero");
    frame({2'b00, 6'h05, 8'h00}, 16, "R6 R3 sample word with new-data flag");
    frame({2'b10, 6'h3F, 8'h01}, 16, "R6 R3 flag cleared, upper address");
    frame({2'b01, 6'h07, 8'h77}, 16, "R8 write leaves return unchanged");
    frame({2'b00, 6'h1A, 8'h00}, 16, "R8 prefix 01 leaves return unchanged");
    frame({2'b11, 6'h15, 8'hFF}, 16, "R3 other word returned");
    check(!spi_fail, "R1 no failure on full frames", {15'd0, spi_fail}, 16'd0);
    sample(14'h0BCD, 1'b0);
    frame({2'b00, 6'h04, 8'h00}, 8, "short");
    check(spi_fail, "R7 short frame flags failure", {15'd0, spi_fail}, 16'd1);
    frame({2'b10, 6'h21, 8'h5A}, 17, "long");
    check(spi_fail, "R7 flag stays set", {15'd0, spi_fail}, 16'd1);
    spi_csn = 1'b1;
    wiggle();
    frame({2'b00, 6'h04, 8'h00}, 16, "R7 R5 return unchanged by bad frames and idle clocks");
    frame({2'b10, 6'h2C, 8'h3C}, 16, "R6 flag kept through short read");
    frame({2'b00, 6'h2B, 8'h00}, 16, "R1 MSB-first write then return");
    frame({2'b10, 6'h00, 8'h00}, 16, "R3 word 21");
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R1 all frames returned", 16'(exp_q.size()), 16'd0);
    check(wr_q.size() == 0, "R2 all writes seen", 16'(wr_q.size()), 16'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule